// File: doc/BRIEF.md
# Mesh Router Output Port Selector

This block picks the output port for a packet header that arrives at a router in a two-dimensional mesh. The header carries two signed hop offsets, one for X and one for Y, that count how far the packet still has to travel. The block also receives a busy flag for each of the four compass ports and a mode bit. When the mode bit is low, the block routes in strict dimension order: X is cleared first, then Y. When the mode bit is high, it uses a west-first turn-restricted scheme that can steer around busy ports.

The result is a one-hot port choice among West, East, South, North and Local. It comes with the header offsets rewritten for the next router: the offset in the dimension that was taken moves one step toward zero. The header, the mode bit and the busy flags are sampled in the cycle that `hdr_vld` is high. The decision appears two clock edges later with a one-cycle `sel_vld` strobe.

Top module: `mesh_port_pick`

## Requirements
- R1: After reset `sel_vld` is 0 and `sel_port` is 0.
- R2: In dimension-order mode (`mode_wf`=0), a negative X offset selects West (`sel_port` bit 0).
- R3: In dimension-order mode, a positive X offset selects East (`sel_port` bit 1) for every Y offset.
- R4: With a zero X offset, a negative Y offset selects South (bit 2) and a positive Y offset selects North (bit 3), in both modes.
- R5: With both offsets zero, Local (bit 4) is selected and both returned offsets are zero.
- R6: In west-first mode (`mode_wf`=1), a negative X offset always selects West, whatever the busy flags.
- R7: In west-first mode, with X offset > 0 and Y offset nonzero, the candidates are East and the Y port toward the destination. East is chosen unless East is busy and that Y port is free. Busy flag positions are: `port_busy` bit 0 West, 1 East, 2 South, 3 North.
- R8: The offset of the dimension taken moves one step toward zero (West adds 1, East subtracts 1, South adds 1, North subtracts 1). The other offset is returned unchanged. Offsets are 4-bit two's complement (-8..+7).
- R9: `sel_vld` is high for exactly the cycle two rising edges after the `hdr_vld` cycle, and `sel_port` is then one-hot.
- R10: In dimension-order mode the busy flags have no effect on the choice.
- R11: Header, mode and busy flags are sampled only in the `hdr_vld` cycle. Changes to them in the following cycle do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_vld | input | 1 | Header present this cycle |
| hdr_dx | input | 4 | Signed X hop offset |
| hdr_dy | input | 4 | Signed Y hop offset |
| mode_wf | input | 1 | 0 dimension order, 1 west-first adaptive |
| port_busy | input | 4 | Busy flags: W, E, S, N in bits 0..3 |
| sel_vld | output | 1 | Decision strobe |
| sel_port | output | 5 | One-hot W, E, S, N, Local in bits 0..4 |
| nxt_dx | output | 4 | X offset for the next hop |
| nxt_dy | output | 4 | Y offset for the next hop |

## Verification
Every result of this block is due at the second rising edge after the `hdr_vld` cycle: the port choice, both rewritten offsets and the strobe. The bench drives a header at a falling edge. At the next falling edge it checks that the strobe is still low, and it also replaces the header and busy flags with different values. It then compares all outputs at the falling edge after the second rising edge. This covers the latency, the sampling in the `hdr_vld` cycle only, and the decision itself. The sweep covers every X and Y offset, both modes and all sixteen busy patterns.

// File: rtl/mpp_pkg.sv
package mpp_pkg;
  localparam int NDIR  = 4;
  localparam int NPORT = NDIR + 1;
  localparam int P_W = 0;
  localparam int P_E = 1;
  localparam int P_S = 2;
  localparam int P_N = 3;
  localparam int P_L = 4;
  typedef logic [NPORT-1:0] port_oh_t;
endpackage

// File: rtl/mpp_capture.sv
module mpp_capture
  import mpp_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic signed [OFS_W-1:0] in_dx,
  input  logic signed [OFS_W-1:0] in_dy,
  input  logic                    in_wf,
  input  logic [NDIR-1:0]         in_busy,
  output logic                    cap_vld,
  output logic signed [OFS_W-1:0] cap_dx,
  output logic signed [OFS_W-1:0] cap_dy,
  output logic                    cap_wf,
  output logic [NDIR-1:0]         cap_busy
);
  logic                    vld_d;
  logic signed [OFS_W-1:0] dx_d, dy_d;
  logic                    wf_d;
  logic [NDIR-1:0]         busy_d;

  // next-state: load fields only on a header
  always_comb begin
    vld_d  = in_vld;
    dx_d   = cap_dx;
    dy_d   = cap_dy;
    wf_d   = cap_wf;
    busy_d = cap_busy;
    if (in_vld) begin
      dx_d   = in_dx;
      dy_d   = in_dy;
      wf_d   = in_wf;
      busy_d = in_busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld  <= 1'b0;
      cap_dx   <= '0;
      cap_dy   <= '0;
      cap_wf   <= 1'b0;
      cap_busy <= '0;
    end else begin
      cap_vld  <= vld_d;
      cap_dx   <= dx_d;
      cap_dy   <= dy_d;
      cap_wf   <= wf_d;
      cap_busy <= busy_d;
    end
  end
endmodule

// File: rtl/mpp_decide.sv
module mpp_decide
  import mpp_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic signed [OFS_W-1:0] dx,
  input  logic signed [OFS_W-1:0] dy,
  input  logic                    wf,
  input  logic [NDIR-1:0]         busy,
  output port_oh_t                port
);
  logic x_neg, x_zero, x_pos;
  logic y_neg, y_zero, y_pos;
  logic y_busy, take_y;
  port_oh_t y_oh;

  assign x_neg  = dx[OFS_W-1];
  assign x_zero = (dx == '0);
  assign x_pos  = !x_neg && !x_zero;
  assign y_neg  = dy[OFS_W-1];
  assign y_zero = (dy == '0);
  assign y_pos  = !y_neg && !y_zero;

  // Y candidate toward the destination and its congestion flag
  always_comb begin
    y_oh = '0;
    if (y_neg) y_oh[P_S] = 1'b1;
    else       y_oh[P_N] = 1'b1;
  end
  assign y_busy = y_neg ? busy[P_S] : busy[P_N];

  // adaptive divert: only when both dimensions remain and X is eastward
  assign take_y = wf && x_pos && !y_zero && busy[P_E] && !y_busy;

  always_comb begin
    port = '0;
    if (x_neg)       port[P_W] = 1'b1;
    else if (take_y) port      = y_oh;
    else if (x_pos)  port[P_E] = 1'b1;
    else if (y_neg)  port[P_S] = 1'b1;
    else if (y_pos)  port[P_N] = 1'b1;
    else             port[P_L] = 1'b1;
  end
endmodule

// File: rtl/mpp_step.sv
module mpp_step #(
  parameter int OFS_W = 4
) (
  input  logic signed [OFS_W-1:0] cur,
  input  logic                    move,
  output logic signed [OFS_W-1:0] nxt
);
  localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);
  always_comb begin
    nxt = cur;
    if (move) begin
      if (cur[OFS_W-1]) nxt = cur + ONE;
      else              nxt = cur - ONE;
    end
  end
endmodule

// File: rtl/mesh_port_pick.sv
module mesh_port_pick
  import mpp_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_vld,
  input  logic [OFS_W-1:0] hdr_dx,
  input  logic [OFS_W-1:0] hdr_dy,
  input  logic             mode_wf,
  input  logic [NDIR-1:0]  port_busy,
  output logic             sel_vld,
  output logic [NPORT-1:0] sel_port,
  output logic [OFS_W-1:0] nxt_dx,
  output logic [OFS_W-1:0] nxt_dy
);
  localparam int NDIM = 2;

  logic                    cap_vld, cap_wf;
  logic signed [OFS_W-1:0] cap_dx, cap_dy;
  logic [NDIR-1:0]         cap_busy;
  port_oh_t                pick;
  logic signed [OFS_W-1:0] cur_ofs  [NDIM];
  logic signed [OFS_W-1:0] step_ofs [NDIM];
  logic [NDIM-1:0]         dim_move;

  logic                    vld_d;
  port_oh_t                port_d;
  logic [OFS_W-1:0]        dx_d, dy_d;

  mpp_capture #(.OFS_W(OFS_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .in_vld(hdr_vld),
    .in_dx($signed(hdr_dx)), .in_dy($signed(hdr_dy)),
    .in_wf(mode_wf), .in_busy(port_busy),
    .cap_vld(cap_vld), .cap_dx(cap_dx), .cap_dy(cap_dy),
    .cap_wf(cap_wf), .cap_busy(cap_busy)
  );

  mpp_decide #(.OFS_W(OFS_W)) u_dec (
    .dx(cap_dx), .dy(cap_dy), .wf(cap_wf), .busy(cap_busy), .port(pick)
  );

  assign cur_ofs[0] = cap_dx;
  assign cur_ofs[1] = cap_dy;
  assign dim_move[0] = pick[P_W] | pick[P_E];
  assign dim_move[1] = pick[P_S] | pick[P_N];

  for (genvar a = 0; a < NDIM; a++) begin : g_dim
    mpp_step #(.OFS_W(OFS_W)) u_step (
      .cur(cur_ofs[a]), .move(dim_move[a]), .nxt(step_ofs[a])
    );
  end

  // next-state for the result register, enabled by the captured strobe
  always_comb begin
    vld_d  = cap_vld;
    port_d = sel_port;
    dx_d   = nxt_dx;
    dy_d   = nxt_dy;
    if (cap_vld) begin
      port_d = pick;
      dx_d   = step_ofs[0];
      dy_d   = step_ofs[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_vld  <= 1'b0;
      sel_port <= '0;
      nxt_dx   <= '0;
      nxt_dy   <= '0;
    end else begin
      sel_vld  <= vld_d;
      sel_port <= port_d;
      nxt_dx   <= dx_d;
      nxt_dy   <= dy_d;
    end
  end
endmodule

// File: rtl/mpp_chk.sv
module mpp_chk
  import mpp_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_vld,
  input logic [OFS_W-1:0] hdr_dx,
  input logic [OFS_W-1:0] hdr_dy,
  input logic             mode_wf,
  input logic [NDIR-1:0]  port_busy,
  input logic             sel_vld,
  input logic [NPORT-1:0] sel_port,
  input logic [OFS_W-1:0] nxt_dx,
  input logic [OFS_W-1:0] nxt_dy
);
  logic                    v1, v2;
  logic signed [OFS_W-1:0] h_dx, h_dy;
  logic                    h_wf;
  logic [NDIR-1:0]         h_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0;
      h_dx <= '0; h_dy <= '0; h_wf <= 1'b0; h_busy <= '0;
    end else begin
      v1 <= hdr_vld;
      v2 <= v1;
      if (hdr_vld) begin
        h_dx <= $signed(hdr_dx); h_dy <= $signed(hdr_dy);
        h_wf <= mode_wf; h_busy <= port_busy;
      end
    end
  end

  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld == v2); // R9
  AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |-> $countones(sel_port) == 1); // R9
  AST_WEST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vld && h_dx < 0) |-> sel_port[P_W]); // R2
  AST_XY_EAST: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vld && !h_wf && h_dx > 0) |-> sel_port[P_E]); // R3
  AST_LOCAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vld && h_dx == 0 && h_dy == 0) |-> (sel_port[P_L] && nxt_dx == '0 && nxt_dy == '0)); // R5
  AST_WF_EAST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vld && h_wf && h_dx > 0 && !h_busy[P_E]) |-> sel_port[P_E]); // R7
  AST_EAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vld && sel_port[P_E]) |-> ($signed(nxt_dx) == h_dx - 1 && $signed(nxt_dy) == h_dy)); // R8
endmodule

bind mesh_port_pick mpp_chk #(.OFS_W(OFS_W)) u_chk (.*);

// File: tb/mesh_port_pick_tb.sv
`timescale 1ns/1ps
module mesh_port_pick_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hdr_vld;
  logic [3:0] hdr_dx, hdr_dy;
  logic       mode_wf;
  logic [3:0] port_busy;
  logic       sel_vld;
  logic [4:0] sel_port;
  logic [3:0] nxt_dx, nxt_dy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mesh_port_pick u_dut (
    .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr_dx(hdr_dx),
    .hdr_dy(hdr_dy), .mode_wf(mode_wf), .port_busy(port_busy),
    .sel_vld(sel_vld), .sel_port(sel_port), .nxt_dx(nxt_dx), .nxt_dy(nxt_dy)
  );

  // model: ports W=0 E=1 S=2 N=3 L=4; busy W=0 E=1 S=2 N=3
  task automatic model(input int dx, input int dy, input bit wf,
                       input logic [3:0] b, output logic [4:0] p,
                       output int ndx, output int ndy, output string tag);
    int yi;
    ndx = dx; ndy = dy; p = '0;
    yi = (dy < 0) ? 2 : 3;
    if (dx < 0) begin
      p[0] = 1'b1; ndx = dx + 1; tag = wf ? "R6 R8" : "R2 R8";
    end else if (dx > 0) begin
      if (wf && dy != 0 && b[1] && !b[yi]) begin
        p[yi] = 1'b1; ndy = (dy < 0) ? dy + 1 : dy - 1; tag = "R7 R8";
      end else begin
        p[1] = 1'b1; ndx = dx - 1;
        tag = wf ? "R7 R8" : "R3 R10 R8";
      end
    end else if (dy < 0) begin
      p[2] = 1'b1; ndy = dy + 1; tag = "R4 R8";
    end else if (dy > 0) begin
      p[3] = 1'b1; ndy = dy - 1; tag = "R4 R8";
    end else begin
      p[4] = 1'b1; tag = "R5";
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] ep;
    int edx, edy;
    string tag;
    rst_n = 1'b0; hdr_vld = 1'b0; hdr_dx = '0; hdr_dy = '0;
    mode_wf = 1'b0; port_busy = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (sel_vld !== 1'b0 || sel_port !== 5'b0) begin
      errors++;
      $display("FAIL R1 vld=%b port=%b exp vld=0 port=00000", sel_vld, sel_port);
    end

    for (int wf = 0; wf < 2; wf++)
      for (int b = 0; b < 16; b++)
        for (int dx = -8; dx < 8; dx++)
          for (int dy = -8; dy < 8; dy++) begin
            model(dx, dy, wf[0], b[3:0], ep, edx, edy, tag);
            hdr_vld = 1'b1; hdr_dx = dx[3:0]; hdr_dy = dy[3:0];
            mode_wf = wf[0]; port_busy = b[3:0];
            @(negedge clk);
            // R11: disturb inputs right after the sampling cycle
            hdr_vld = 1'b0; hdr_dx = ~dx[3:0]; hdr_dy = ~dy[3:0];
            mode_wf = ~wf[0]; port_busy = ~b[3:0];
            checks++;
            if (sel_vld !== 1'b0) begin
              errors++;
              $display("FAIL R9 early strobe vld=%b exp=0", sel_vld);
            end
            @(negedge clk);
            checks++;
            if (sel_vld !== 1'b1 || sel_port !== ep ||
                $signed(nxt_dx) != edx || $signed(nxt_dy) != edy) begin
              errors++;
              $display("FAIL %s R9 R11 wf=%0d busy=%b dx=%0d dy=%0d: vld=%b exp=1 port=%b exp=%b ndx=%0d exp=%0d ndy=%0d exp=%0d",
                       tag, wf, b[3:0], dx, dy, sel_vld, sel_port, ep,
                       $signed(nxt_dx), edx, $signed(nxt_dy), edy);
            end
          end

    @(negedge clk);
    checks++;
    if (sel_vld !== 1'b0) begin
      errors++;
      $display("FAIL R9 strobe longer than one cycle vld=%b exp=0", sel_vld);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule